// File: doc/BRIEF.md
# Strobed Bidirectional Byte Port

This block is a parallel port that moves bytes in both directions over one shared set of data pads. Four handshake pins go with the pads. The processor writes a byte into the port. The port then pulls `out_full_n` low to say the byte is waiting. An external peer takes the byte by pulling `peer_ack_n` low, and the port drives the pads only while that acknowledge is held low. When the acknowledge is released, the output side is free again.

In the other direction, the peer places a byte on the pads and pulses `peer_stb_n` low. The port keeps the value that was present while the strobe was low and commits it when the strobe rises. It then raises `in_full` until the processor reads the byte.

The processor side is a small register interface with two registers: a data register and a status register. Both handshake pins and the pads are first passed through a synchronizer. Each flag therefore follows its pin edge within four clock cycles.

The transmit engine has three states:
- `TX_IDLE` moves to `TX_FULL` on an accepted write.
- `TX_FULL` moves to `TX_ACKED` on a falling acknowledge.
- `TX_ACKED` returns to `TX_IDLE` on a rising acknowledge.

The receive engine has five states:
- `RX_EMPTY` moves to `RX_LOAD` on a falling strobe.
- `RX_LOAD` moves to `RX_FULL` on a rising strobe, which commits the byte.
- `RX_FULL` moves to `RX_EMPTY` on a data read. It moves to `RX_LOAD` on a read and a strobe fall in the same cycle. It moves to `RX_SPILL` on a strobe fall without a read, which is an overrun.
- `RX_SPILL` moves to `RX_FULL` on a strobe rise, and the new byte is discarded. It moves to `RX_DROP` on a read, and to `RX_EMPTY` on a read and a strobe rise together.
- `RX_DROP` moves to `RX_EMPTY` on a strobe rise.

Top module: `duplex_port`

## Requirements
- R1: After reset, `out_full_n` is high, `in_full` is low, the pads are released, and the status register reads as zero.
- R2: A write to the data register (`cpu_stat_sel`=0) while no output byte is pending stores the byte and pulls `out_full_n` low on the next clock.
- R3: The pads carry the stored output byte only while an output byte is pending and `peer_ack_n` is low. At all other times the port leaves them undriven.
- R4: A rising edge on `peer_ack_n` after an acknowledge returns `out_full_n` high within four cycles. After that, a new write is accepted.
- R5: A data write while `out_full_n` is low is refused. The pending byte does not change, and status bit 3 (write refused) is set.
- R6: The byte present on the pads while `peer_stb_n` is low is committed when the strobe rises. `in_full` then goes high within four cycles.
- R7: A data read (`cpu_rd`, `cpu_stat_sel`=0) returns the committed byte on `cpu_rdata` one cycle later and clears `in_full`.
- R8: A strobe falling edge while `in_full` is high sets status bit 2 (overrun). The held byte and `in_full` are kept, and the new byte is discarded.
- R9: A status read returns these bits, with all other bits zero: bit 0 = output byte pending, bit 1 = `in_full`, bit 2 = overrun, bit 3 = write refused. The read clears bits 2 and 3.
- R10: Input transfers work while an output byte is pending and unacknowledged. A byte strobed in during that time is received unaltered.
- R11: Pulsing `peer_ack_n` low while no output byte is pending has no effect. A later write is still accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_stat_sel | input | 1 | Register select: 0 data, 1 status |
| cpu_wr | input | 1 | Processor write strobe, one cycle |
| cpu_rd | input | 1 | Processor read strobe, one cycle |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, valid the cycle after `cpu_rd` |
| pad_data | inout | DW | Shared bidirectional data pads |
| out_full_n | output | 1 | Low while an output byte waits for the peer |
| peer_ack_n | input | 1 | Peer acknowledge, active low |
| peer_stb_n | input | 1 | Peer input strobe, active low |
| in_full | output | 1 | High while an input byte waits for the processor |

## Verification
The assertions check these rules on every cycle:
- `out_full_n` only falls after an accepted write, and only rises after an acknowledge release.
- A refused write leaves the pending byte unchanged.
- `in_full` only falls on a data read and otherwise holds.
- An overrun event always leaves the overrun flag set.
- The pads are only driven while an output byte is pending.

The bench scenarios are needed for the end-to-end results. These are the actual byte values seen by the peer and the processor, the release of the pads shown by an input byte arriving intact while output is pending, the clearing of sticky flags by status reads, and the absence of any effect from a stray acknowledge.

// File: rtl/dport_pkg.sv
package dport_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_FULL  = 2'd1,
        TX_ACKED = 2'd2
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_EMPTY = 3'd0,
        RX_LOAD  = 3'd1,
        RX_FULL  = 3'd2,
        RX_SPILL = 3'd3,
        RX_DROP  = 3'd4
    } rx_state_e;

    localparam int unsigned ST_PEND = 0;
    localparam int unsigned ST_INF  = 1;
    localparam int unsigned ST_OVR  = 2;
    localparam int unsigned ST_REF  = 3;
    localparam int unsigned ST_BITS = 4;

endpackage

// File: rtl/dport_sync.sv
module dport_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= {W{RST_VAL}};
                end else begin
                    if (g == 0) chain[g] <= d;
                    else        chain[g] <= chain[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dport_tx.sv
module dport_tx
    import dport_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_byte,
    input  logic          ack_s,
    input  logic          ack_raw,
    output logic          full_n,
    output logic          pad_oe,
    output logic [DW-1:0] out_byte,
    output logic          refused
);
    tx_state_e state, state_nx;
    logic      ack_prev;
    logic      ack_fall, ack_rise;

    assign ack_fall = ack_prev & ~ack_s;
    assign ack_rise = ~ack_prev & ack_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= TX_IDLE;
            ack_prev <= 1'b1;
            out_byte <= '0;
        end else begin
            state    <= state_nx;
            ack_prev <= ack_s;
            if (state == TX_IDLE && wr_req) out_byte <= wr_byte;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:  if (wr_req)   state_nx = TX_FULL;
            TX_FULL:  if (ack_fall) state_nx = TX_ACKED;
            TX_ACKED: if (ack_rise) state_nx = TX_IDLE;
            default:                state_nx = TX_IDLE;
        endcase
    end

    always_comb begin
        full_n  = (state == TX_IDLE);
        pad_oe  = (state != TX_IDLE) && !ack_raw;
        refused = wr_req && (state != TX_IDLE);
    end

    assert_full_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_n) |-> $past(wr_req));

    assert_release_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_ACKED && ack_rise) |=> full_n);
endmodule

// File: rtl/dport_rx.sv
module dport_rx
    import dport_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb_s,
    input  logic [DW-1:0] dat_s,
    input  logic          rd_take,
    output logic          full,
    output logic [DW-1:0] in_byte,
    output logic          ovr_evt
);
    rx_state_e     state, state_nx;
    logic          stb_prev;
    logic          stb_fall, stb_rise;
    logic [DW-1:0] stage;

    assign stb_fall = stb_prev & ~stb_s;
    assign stb_rise = ~stb_prev & stb_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= RX_EMPTY;
            stb_prev <= 1'b1;
            stage    <= '0;
            in_byte  <= '0;
        end else begin
            state    <= state_nx;
            stb_prev <= stb_s;
            if (!stb_s) stage <= dat_s;
            if (state == RX_LOAD && stb_rise) in_byte <= stage;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_EMPTY: if (stb_fall) state_nx = RX_LOAD;
            RX_LOAD:  if (stb_rise) state_nx = RX_FULL;
            RX_FULL: begin
                if (rd_take && stb_fall) state_nx = RX_LOAD;
                else if (rd_take)        state_nx = RX_EMPTY;
                else if (stb_fall)       state_nx = RX_SPILL;
            end
            RX_SPILL: begin
                if (rd_take && stb_rise) state_nx = RX_EMPTY;
                else if (rd_take)        state_nx = RX_DROP;
                else if (stb_rise)       state_nx = RX_FULL;
            end
            RX_DROP:  if (stb_rise) state_nx = RX_EMPTY;
            default:                state_nx = RX_EMPTY;
        endcase
    end

    always_comb begin
        full    = (state == RX_FULL) || (state == RX_SPILL);
        ovr_evt = (state == RX_FULL) && stb_fall && !rd_take;
    end

    assert_clear_only_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full) |-> $past(rd_take));

    assert_hold_while_unread_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_take) |=> full);
endmodule

// File: rtl/duplex_port.sv
module duplex_port
    import dport_pkg::*;
#(
    parameter int unsigned DW          = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_stat_sel,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    inout  wire  [DW-1:0] pad_data,
    output logic          out_full_n,
    input  logic          peer_ack_n,
    input  logic          peer_stb_n,
    output logic          in_full
);
    localparam int unsigned RXW = DW + 1;

    logic          ack_s;
    logic [RXW-1:0] rx_raw, rx_s;
    logic          wr_data, rd_data, rd_stat;
    logic          pad_oe, refused, ovr_evt;
    logic [DW-1:0] out_byte, in_byte;
    logic          ovr_flag, ref_flag;
    logic [DW-1:0] stat_word;

    assign wr_data = cpu_wr && !cpu_stat_sel;
    assign rd_data = cpu_rd && !cpu_stat_sel;
    assign rd_stat = cpu_rd &&  cpu_stat_sel;
    assign rx_raw  = {peer_stb_n, pad_data};

    dport_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(peer_ack_n), .q(ack_s)
    );

    dport_sync #(.W(RXW), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
        .clk(clk), .rst_n(rst_n), .d(rx_raw), .q(rx_s)
    );

    dport_tx #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_data), .wr_byte(cpu_wdata),
        .ack_s(ack_s), .ack_raw(peer_ack_n), .full_n(out_full_n),
        .pad_oe(pad_oe), .out_byte(out_byte), .refused(refused)
    );

    dport_rx #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .stb_s(rx_s[DW]), .dat_s(rx_s[DW-1:0]),
        .rd_take(rd_data), .full(in_full), .in_byte(in_byte), .ovr_evt(ovr_evt)
    );

    assign pad_data = pad_oe ? out_byte : {DW{1'bz}};

    always_comb begin
        stat_word          = '0;
        stat_word[ST_PEND] = !out_full_n;
        stat_word[ST_INF]  = in_full;
        stat_word[ST_OVR]  = ovr_flag;
        stat_word[ST_REF]  = ref_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_flag  <= 1'b0;
            ref_flag  <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            if (ovr_evt)      ovr_flag <= 1'b1;
            else if (rd_stat) ovr_flag <= 1'b0;
            if (refused)      ref_flag <= 1'b1;
            else if (rd_stat) ref_flag <= 1'b0;
            if (rd_stat)      cpu_rdata <= stat_word;
            else if (rd_data) cpu_rdata <= in_byte;
        end
    end

    assert_refused_keeps_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !out_full_n) |=> (ref_flag && $stable(out_byte)));

    assert_overrun_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> ovr_flag);

    assert_drive_only_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> !out_full_n);
endmodule

// File: tb/duplex_port_bench.sv
`timescale 1ns/1ps
module duplex_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_stat_sel = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    wire  [7:0] pad;
    logic       out_full_n, in_full;
    logic       ack_mon = 1'b1, ack_probe = 1'b1;
    logic       peer_stb_n = 1'b1;
    logic       ext_en = 1'b0;
    logic [7:0] ext_val = '0;
    logic       auto_ack = 1'b0;
    logic       peer_ack_n;
    int         checks = 0, errors = 0;
    logic [7:0] out_q[$];
    logic [7:0] in_q[$];

    assign peer_ack_n = ack_mon & ack_probe;
    assign pad = ext_en ? ext_val : 8'bz;

    always #2.5 clk = ~clk;

    duplex_port u_duplex_port (
        .clk(clk), .rst_n(rst_n), .cpu_stat_sel(cpu_stat_sel), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .pad_data(pad), .out_full_n(out_full_n), .peer_ack_n(peer_ack_n),
        .peer_stb_n(peer_stb_n), .in_full(in_full)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [7:0] b, input logic expect_ok);
        @(negedge clk);
        cpu_stat_sel = 1'b0; cpu_wdata = b; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        if (expect_ok) out_q.push_back(b);
    endtask

    task automatic cpu_read(input logic sel, output logic [7:0] v);
        @(negedge clk);
        cpu_stat_sel = sel; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        v = cpu_rdata;
    endtask

    task automatic strobe_in(input logic [7:0] b, input logic keep);
        @(negedge clk);
        ext_val = b; ext_en = 1'b1;
        @(negedge clk);
        peer_stb_n = 1'b0;
        repeat (4) @(negedge clk);
        peer_stb_n = 1'b1;
        @(negedge clk);
        ext_en = 1'b0;
        repeat (4) @(negedge clk);
        if (keep) in_q.push_back(b);
    endtask

    task automatic read_and_score(input string req);
        logic [7:0] v, e;
        cpu_read(1'b0, v);
        e = (in_q.size() != 0) ? in_q.pop_front() : 8'hxx;
        check(req, v, e);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60 && out_full_n !== 1'b1; i++) @(negedge clk);
    endtask

    // Monitor: plays the peer on the output side and scores received bytes
    initial begin
        forever begin
            @(negedge clk);
            if (auto_ack && out_full_n === 1'b0) begin
                repeat (3) @(negedge clk);
                ack_mon = 1'b0;
                repeat (3) @(negedge clk);
                checks++;
                if (out_q.size() == 0) begin
                    errors++;
                    $display("FAIL R3: actual %h expected none", pad);
                end else begin
                    logic [7:0] e;
                    e = out_q.pop_front();
                    if (pad !== e) begin
                        errors++;
                        $display("FAIL R3: actual %h expected %h", pad, e);
                    end
                end
                ack_mon = 1'b1;
                repeat (2) @(negedge clk);
            end
        end
    end

    initial begin
        #(200000 * 5.0);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 full_n", {7'd0, out_full_n}, 8'h01);
        check("R1 in_full", {7'd0, in_full}, 8'h00);
        cpu_read(1'b1, v);
        check("R1 R9 status", v, 8'h00);

        cpu_write(8'h5A, 1'b1);
        check("R2 full_n low", {7'd0, out_full_n}, 8'h00);
        cpu_read(1'b1, v);
        check("R9 pending bit", v, 8'h01);

        cpu_write(8'h33, 1'b0);
        cpu_read(1'b1, v);
        check("R5 refused bit", v, 8'h09);
        cpu_read(1'b1, v);
        check("R9 refused cleared", v, 8'h01);

        auto_ack = 1'b1;
        wait_idle();
        check("R4 full_n high", {7'd0, out_full_n}, 8'h01);
        check("R3 R5 scored", 8'(out_q.size()), 8'h00);
        cpu_write(8'hC3, 1'b1);
        check("R4 rewrite", {7'd0, out_full_n}, 8'h00);
        wait_idle();
        check("R4 second byte", 8'(out_q.size()), 8'h00);
        auto_ack = 1'b0;

        strobe_in(8'h96, 1'b1);
        check("R6 in_full", {7'd0, in_full}, 8'h01);
        read_and_score("R7 data");
        check("R7 in_full cleared", {7'd0, in_full}, 8'h00);

        strobe_in(8'h11, 1'b1);
        strobe_in(8'h22, 1'b0);
        cpu_read(1'b1, v);
        check("R8 overrun status", v, 8'h06);
        read_and_score("R8 held byte");
        cpu_read(1'b1, v);
        check("R9 overrun cleared", v, 8'h00);

        cpu_write(8'h5A, 1'b1);
        strobe_in(8'hA5, 1'b1);
        read_and_score("R10 input while pending");
        check("R10 still pending", {7'd0, out_full_n}, 8'h00);
        auto_ack = 1'b1;
        wait_idle();
        check("R10 output done", 8'(out_q.size()), 8'h00);
        auto_ack = 1'b0;

        @(negedge clk);
        ack_probe = 1'b0;
        repeat (5) @(negedge clk);
        ack_probe = 1'b1;
        repeat (5) @(negedge clk);
        check("R11 full_n", {7'd0, out_full_n}, 8'h01);
        cpu_read(1'b1, v);
        check("R11 status", v, 8'h00);
        cpu_write(8'h7E, 1'b1);
        check("R11 write taken", {7'd0, out_full_n}, 8'h00);
        auto_ack = 1'b1;
        wait_idle();
        check("R11 byte delivered", 8'(out_q.size()), 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule